// File: doc/BRIEF.md
# Branch Resolution and Slot Annul Controller

This block is the control-flow front end of a five-stage in-order pipeline. Branches and jumps are resolved in decode. When decode resolves a branch, the next sequential instruction has already been fetched, one cycle after the branch. The block owns the fetch program counter and the valid bit of the fetch/decode pipeline register. Each cycle it chooses the next fetch address: the branch target for a taken branch, and otherwise the current address plus one instruction width. It also decides whether the instruction now leaving fetch, the "shadow slot", enters decode as a live instruction or as a bubble.

A static two-bit selector picks one of three annul policies for the shadow slot:

- **Fall-through** keeps the slot only when the branch is not taken. A taken branch therefore costs one lost issue slot.
- **Likely** keeps the slot only when the branch is taken.
- **Delay-slot** always keeps the slot.

An annulled instruction keeps its encoding; only its valid bit is cleared. A front-end stall from the interlock freezes the fetch address, the decode register and the pending annul decision. Any branch indication arriving while decode holds no live instruction is ignored.

The decode slot is a three-state machine: `SLOT_EMPTY` (nothing fetched yet, after reset), `SLOT_LIVE` (a valid instruction) and `SLOT_VOID` (an annulled instruction). The transitions are:

- `fill`: from any state to `SLOT_LIVE` on an unstalled cycle without kill.
- `annul`: from any state to `SLOT_VOID` on an unstalled cycle with kill.
- `hold`: no change while stalled.
- `reset`: to `SLOT_EMPTY`.

Top module: `bra_annul_ctrl`

## Requirements
- R1: During and directly after reset, `fetch_pc` equals parameter `RESET_PC` (default 0x0000_1000) and `dec_live` is 0; the first unstalled edge after reset makes `dec_live` 1 with `dec_pc` = `RESET_PC`.
- R2: When decode holds no live taken branch, `next_pc` is `fetch_pc` + 4 and an unstalled edge loads it into `fetch_pc`.
- R3: When decode holds a live branch (`dec_live`=1, `br_valid`=1) with `br_taken`=1, `next_pc` equals `br_target` and `fetch_pc` takes that value at the next unstalled edge.
- R4: With `policy`=2'b00 (fall-through), `slot_kill` is 1 for a live taken branch and 0 for a live not-taken branch; after the edge `dec_live` equals the inverse of `slot_kill`.
- R5: With `policy`=2'b01 (likely), `slot_kill` is 1 for a live not-taken branch and 0 for a live taken branch.
- R6: With `policy`=2'b10 (delay-slot), `slot_kill` is 0 for every branch and the shadow slot always enters decode live.
- R7: While `stall`=1, `fetch_pc`, `dec_pc` and `dec_live` keep their values; the branch held in decode is acted on at the first edge with `stall`=0.
- R8: When `dec_live`=0, `br_valid` and `br_taken` have no effect: `slot_kill` is 0 and `next_pc` is `fetch_pc` + 4.
- R9: `policy`=2'b11 behaves as fall-through.
- R10: After each unstalled edge, `dec_pc` holds the `fetch_pc` value from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Interlock stall; freezes fetch and decode |
| policy | input | 2 | Annul policy: 00 fall-through, 01 likely, 10 delay-slot, 11 as 00 |
| br_valid | input | 1 | Decode instruction is a branch or jump |
| br_taken | input | 1 | Resolved outcome of the decode branch |
| br_target | input | ADDR_W | Resolved target address |
| fetch_pc | output | ADDR_W | Address being fetched this cycle |
| next_pc | output | ADDR_W | Address to fetch next cycle |
| slot_kill | output | 1 | Shadow slot leaving fetch is annulled |
| dec_pc | output | ADDR_W | Address of the instruction held in decode |
| dec_live | output | 1 | Valid bit of the decode register |

## Verification
A wrong slot state shows at `dec_live` one edge after the faulty decision. If that state is a falsely live slot, the next branch can be acted on wrongly, which shows in `next_pc` in the same cycle. A wrong redirect shows at `fetch_pc` one edge later, and at `dec_pc` one edge after that. A stall that leaks lets `fetch_pc` move during the stall, so the very first frozen cycle exposes it.

// File: rtl/bra_pkg.sv
package bra_pkg;
    typedef enum logic [1:0] {
        POL_FALL   = 2'b00,
        POL_LIKELY = 2'b01,
        POL_DELAY  = 2'b10,
        POL_SPARE  = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'b00,
        SLOT_LIVE  = 2'b01,
        SLOT_VOID  = 2'b10
    } slot_e;
endpackage

// File: rtl/bra_annul_policy.sv
module bra_annul_policy
    import bra_pkg::*;
(
    input  logic [1:0] policy,
    input  logic       live_branch,
    input  logic       taken,
    output logic       kill
);
    policy_e pol;
    assign pol = policy_e'(policy);

    always_comb begin
        kill = 1'b0;
        if (live_branch) begin
            unique case (pol)
                POL_FALL:   kill = taken;
                POL_LIKELY: kill = !taken;
                POL_DELAY:  kill = 1'b0;
                POL_SPARE:  kill = taken;   // R9: spare code acts as fall-through
                default:    kill = 1'b0;
            endcase
        end
    end

    always_comb begin
        a_r8_no_kill_without_branch: assert (live_branch || !kill);
    end
endmodule

// File: rtl/bra_next_pc.sv
module bra_next_pc #(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] nxt_pc
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    logic [ADDR_W-1:0] seq_pc;
    assign seq_pc = cur_pc + STEP;

    always_comb begin
        nxt_pc = redirect ? target : seq_pc;
    end
endmodule

// File: rtl/bra_slot_fsm.sv
module bra_slot_fsm
    import bra_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              kill,
    input  logic [ADDR_W-1:0] nxt_pc,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] dec_pc,
    output logic              dec_live
);
    slot_e state_q, state_d;

    // next-state selection: fill, annul, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY, SLOT_LIVE, SLOT_VOID: begin
                if (!stall) state_d = kill ? SLOT_VOID : SLOT_LIVE;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc <= RESET_PC;
            dec_pc   <= RESET_PC;
        end else if (!stall) begin
            fetch_pc <= nxt_pc;
            dec_pc   <= fetch_pc;
        end
    end

    // outputs decoded from state
    always_comb begin
        dec_live = 1'b0;
        unique case (state_q)
            SLOT_LIVE:             dec_live = 1'b1;
            SLOT_EMPTY, SLOT_VOID: dec_live = 1'b0;
            default:               dec_live = 1'b0;
        endcase
    end

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(fetch_pc) && $stable(dec_pc) && $stable(dec_live)));

    a_r10_dec_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (dec_pc == $past(fetch_pc)));
endmodule

// File: rtl/bra_annul_ctrl.sv
module bra_annul_ctrl
    import bra_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                INSTR_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_PC    = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [1:0]        policy,
    input  logic              br_valid,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              slot_kill,
    output logic [ADDR_W-1:0] dec_pc,
    output logic              dec_live
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    logic live_branch;
    logic redirect;

    assign live_branch = dec_live && br_valid;
    assign redirect    = live_branch && br_taken;

    bra_annul_policy u_policy (
        .policy      (policy),
        .live_branch (live_branch),
        .taken       (br_taken),
        .kill        (slot_kill)
    );

    bra_next_pc #(
        .ADDR_W      (ADDR_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_npc (
        .cur_pc   (fetch_pc),
        .redirect (redirect),
        .target   (br_target),
        .nxt_pc   (next_pc)
    );

    bra_slot_fsm #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .kill     (slot_kill),
        .nxt_pc   (next_pc),
        .fetch_pc (fetch_pc),
        .dec_pc   (dec_pc),
        .dec_live (dec_live)
    );

    a_r3_taken_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && dec_live && br_valid && br_taken) |=> (fetch_pc == $past(br_target)));

    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !(dec_live && br_valid && br_taken)) |=> (fetch_pc == $past(fetch_pc) + STEP));

    a_r4_fall_taken_void: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && dec_live && br_valid && br_taken && policy == 2'b00) |=> !dec_live);

    a_r6_delay_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && policy == 2'b10) |=> dec_live);
endmodule

// File: tb/tb_bra_annul_ctrl.sv
module tb_bra_annul_ctrl;
    localparam int          AW   = 32;
    localparam logic [31:0] RPC  = 32'h0000_1000;
    localparam int          NV   = 8;

    // table: policy, taken, expected kill
    localparam logic [1:0] V_POL  [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11};
    localparam logic       V_TK   [NV] = '{1'b1,  1'b0,  1'b1,  1'b0,  1'b1,  1'b0,  1'b1,  1'b0};
    localparam logic       V_KILL [NV] = '{1'b1,  1'b0,  1'b0,  1'b1,  1'b0,  1'b0,  1'b1,  1'b0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic [1:0]    policy = 2'b00;
    logic          br_valid = 1'b0;
    logic          br_taken = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [AW-1:0] fetch_pc, next_pc, dec_pc;
    logic          slot_kill, dec_live;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bra_annul_ctrl #(.ADDR_W(AW), .INSTR_BYTES(4), .RESET_PC(RPC)) dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .policy(policy),
        .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
        .fetch_pc(fetch_pc), .next_pc(next_pc), .slot_kill(slot_kill),
        .dec_pc(dec_pc), .dec_live(dec_live)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic string pol_req(input logic [1:0] p);
        case (p)
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R9";
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pc0, pcs, tgt;
        step();
        step();
        chk("R1 fetch_pc in reset", fetch_pc, RPC);
        chk("R1 dec_live in reset", {31'b0, dec_live}, 32'd0);
        rst_n = 1'b1;
        chk("R1 fetch_pc after reset", fetch_pc, RPC);
        step();
        chk("R1 first fill live", {31'b0, dec_live}, 32'd1);
        chk("R1 first dec_pc", dec_pc, RPC);
        chk("R2 first advance", fetch_pc, RPC + 32'd4);

        // table walk
        for (int i = 0; i < NV; i++) begin
            br_valid = 1'b0;
            policy = V_POL[i];
            pc0 = fetch_pc;
            step();
            chk("R10 filler live", {31'b0, dec_live}, 32'd1);
            chk("R2 filler advance", fetch_pc, pc0 + 32'd4);
            tgt = 32'h0000_2000 + 32'h100 * 32'(i);
            br_valid = 1'b1;
            br_taken = V_TK[i];
            br_target = tgt;
            #1;
            pcs = fetch_pc;
            chk(pol_req(V_POL[i]), {31'b0, slot_kill}, {31'b0, V_KILL[i]});
            chk(V_TK[i] ? "R3 next_pc target" : "R2 next_pc seq", next_pc,
                V_TK[i] ? tgt : pcs + 32'd4);
            step();
            chk(V_TK[i] ? "R3 redirect" : "R2 fall-through", fetch_pc,
                V_TK[i] ? tgt : pcs + 32'd4);
            chk(pol_req(V_POL[i]), {31'b0, dec_live}, {31'b0, ~V_KILL[i]});
            chk("R10 slot pc", dec_pc, pcs);
            br_valid = 1'b0;
        end

        // stall holds the pending decision
        br_valid = 1'b0;
        policy = 2'b00;
        step();
        chk("R7 pre-stall live", {31'b0, dec_live}, 32'd1);
        br_valid = 1'b1;
        br_taken = 1'b1;
        br_target = 32'h0000_3000;
        stall = 1'b1;
        pc0 = fetch_pc;
        pcs = dec_pc;
        step();
        step();
        chk("R7 fetch_pc held", fetch_pc, pc0);
        chk("R7 dec_pc held", dec_pc, pcs);
        chk("R7 dec_live held", {31'b0, dec_live}, 32'd1);
        stall = 1'b0;
        step();
        chk("R7 released redirect", fetch_pc, 32'h0000_3000);
        chk("R4 released annul", {31'b0, dec_live}, 32'd0);

        // branch seen while decode is void is ignored
        br_valid = 1'b1;
        br_taken = 1'b1;
        br_target = 32'h0000_4000;
        #1;
        chk("R8 no kill when void", {31'b0, slot_kill}, 32'd0);
        chk("R8 next_pc seq when void", next_pc, 32'h0000_3004);
        step();
        chk("R8 no redirect when void", fetch_pc, 32'h0000_3004);
        chk("R8 slot live", {31'b0, dec_live}, 32'd1);
        br_valid = 1'b0;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule